// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

A single-port synchronous static memory with a 32-bit word made of four byte lanes. The chip select, an address-load strobe, the advance input and the write controls are sampled on each rising clock edge. A load captures a base address. After that, each cycle with advance asserted steps the two low address bits through a four-beat burst. A mode input picks the burst order: interleaved, where the start bits are XORed with the beat number, or linear, where the start bits are incremented with wrap-around.

Reads are flow-through. The sampled command and address sit in registers, and the array output reaches the read port through combinational logic only, in the cycle after the edge that took the command. A write command is taken at one edge, and its data is taken from the write port at the next edge. The write decode has three layers: a global write enable, a byte-write master and one enable per lane.

The bus drive is shown on a separate enable output, which stands for the high-impedance state. The drive is gated at once by the output enable and by a sleep input. Sleep also cancels any access in progress.

Top module: `sram_ft`

## Requirements
- R1: With the chip select low and the load strobe low at an edge, the address input becomes the access address for the next cycle, and the burst starts at beat 0.
- R2: With the mode input high, the low address bits step through start XOR 0, 1, 2, 3 on successive advances. A start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01. The upper address bits do not change.
- R3: With the mode input low, the low address bits step by +1 modulo 4 on each advance. A start of 01 gives 01, 10, 11, 00, and a start of 11 gives 11, 00, 01, 10. A fifth advance returns to the start.
- R4: A cycle with the chip select low, no load and the advance input high keeps the same address as the cycle before.
- R5: A low global write enable writes all four lanes, whatever the master and per-lane enables are.
- R6: With the global enable high and the master low, lane n (bits 8n+7:8n, lane a = bits 7:0, lane d = bits 31:24) is written only when bit n of the per-lane enable is low.
- R7: With the global and master enables both high, the cycle is a read and the per-lane enables change no stored byte.
- R8: The data of a write is taken at the edge after its command. Read data comes from the array in the cycle after the command edge, with no output register, so a read that follows a write to the same address shows the new data.
- R9: The drive enable is high only during a read cycle with the output enable low. It drops in the same cycle the output enable goes high, and it stays low during write cycles.
- R10: A cycle with the chip select high performs no new access and drives nothing. Afterwards, advance pulses have no effect until a new load.
- R11: A high sleep input turns the drive off at once, ends the access, and drops a write whose data edge falls while sleep is high. Stored contents are kept.
- R12: After reset, no access is active and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the burst state |
| sleep | input | 1 | Power-down request, active high (tie low when unused) |
| cs_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Address-load strobe, active low; starts a burst |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | AW | Word address |
| gw_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low, bit n = lane n |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 8*LANES | Write data, sampled at the edge after a write command |
| rdata | output | 8*LANES | Read data (zero when not driven) |
| rdata_en | output | 1 | High when the block drives the bus; low stands for high impedance |

## Verification
The bench goes after the burst turning points. It checks both interleaved starting points, where the step from beat 1 to beat 2 flips both low bits; a counter that simply adds would read the wrong word there. It also checks the linear wrap from 11 to 00, where a counter that carried into bit 2 would leave the four-word block. The write decode is tested with the global enable low while the per-lane enables are mixed or all high. A decode that let the per-lane enables override the global one would keep some old bytes. A master-high read with all lane enables low must leave the word unchanged. Deselect, output enable and sleep are each applied in the middle of an access. This catches a block that keeps driving, resumes a stale burst, or commits a write whose data edge fell during sleep.

// File: rtl/sram_ft.sv
module sram_ft #(
  parameter int AW    = 10,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep,
  input  logic               cs_n,
  input  logic               load_n,
  input  logic               adv_n,
  input  logic               ilv_mode,
  input  logic [AW-1:0]      addr,
  input  logic               gw_n,
  input  logic               bwe_n,
  input  logic [LANES-1:0]   bw_n,
  input  logic               oe_n,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata,
  output logic               rdata_en
);
  localparam int DW    = 8 * LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic             act_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       beat_q;
  logic [LANES-1:0] wmask_q;
  logic [LANES-1:0] wmask_d;
  logic [1:0]       lo;
  logic [AW-1:0]    cur_addr;

  assign lo       = ilv_mode ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);
  assign cur_addr = {base_q[AW-1:2], lo};
  assign wmask_d  = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
  assign rdata_en = act_q && (wmask_q == '0) && !oe_n && !sleep;
  assign rdata    = rdata_en ? mem[cur_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      wmask_q <= '0;
    end else if (sleep || cs_n) begin
      act_q   <= 1'b0;
      beat_q  <= '0;
      wmask_q <= '0;
    end else if (!load_n) begin
      act_q   <= 1'b1;
      base_q  <= addr;
      beat_q  <= '0;
      wmask_q <= wmask_d;
    end else if (act_q) begin
      if (!adv_n) beat_q <= beat_q + 2'd1;
      wmask_q <= wmask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !sleep && act_q) begin
      for (int i = 0; i < LANES; i++)
        if (wmask_q[i]) mem[cur_addr][8*i +: 8] <= wdata[8*i +: 8];
    end
  end
endmodule

// File: rtl/sram_ft_chk.sv
module sram_ft_chk #(
  parameter int AW    = 10,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             cs_n,
  input logic             load_n,
  input logic             adv_n,
  input logic             ilv_mode,
  input logic             oe_n,
  input logic [AW-1:0]    addr,
  input logic             rdata_en,
  input logic             act_q,
  input logic [LANES-1:0] wmask_q,
  input logic [AW-1:0]    cur_addr
);
  p_load_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !sleep && !cs_n && !load_n) |-> (act_q && cur_addr == $past(addr)));

  p_ilv_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && !sleep && !cs_n && load_n && !adv_n && act_q && ilv_mode) && ilv_mode)
    |-> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]) && cur_addr[1:0] != $past(cur_addr[1:0])));

  p_lin_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && !sleep && !cs_n && load_n && !adv_n && act_q && !ilv_mode) && !ilv_mode)
    |-> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]) && cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && !sleep && !cs_n && load_n && adv_n && act_q) && ilv_mode == $past(ilv_mode))
    |-> $stable(cur_addr));

  p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !rdata_en);

  p_write_nodrive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && wmask_q != '0) |-> !rdata_en);

  p_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && cs_n) |-> (!act_q && !rdata_en));

  p_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && sleep) |-> !act_q);

  p_sleep_off_r11: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !rdata_en);
endmodule

bind sram_ft sram_ft_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs_n(cs_n), .load_n(load_n),
  .adv_n(adv_n), .ilv_mode(ilv_mode), .oe_n(oe_n), .addr(addr),
  .rdata_en(rdata_en), .act_q(act_q), .wmask_q(wmask_q), .cur_addr(cur_addr)
);

// File: tb/tb_sram_ft.sv
module tb_sram_ft;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0, sleep = 0, cs_n = 1, load_n = 1, adv_n = 1, ilv_mode = 0;
  logic gw_n = 1, bwe_n = 1, oe_n = 0;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rdata_en;
  int checks = 0, fails = 0;
  bit finished = 0;

  // {gw_n, bwe_n, bw_n[3:0], expected lane mask[3:0]}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b1, 4'b1111, 4'b1111},
    {1'b0, 1'b0, 4'b0101, 4'b1111},
    {1'b1, 1'b0, 4'b1110, 4'b0001},
    {1'b1, 1'b0, 4'b0011, 4'b1100},
    {1'b1, 1'b0, 4'b0000, 4'b1111},
    {1'b1, 1'b1, 4'b0000, 4'b0000}
  };

  sram_ft #(.AW(AW), .LANES(4)) dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs_n(cs_n), .load_n(load_n),
    .adv_n(adv_n), .ilv_mode(ilv_mode), .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic ld, input logic av, input logic g,
                      input logic bm, input logic [3:0] b, input logic [AW-1:0] a,
                      input logic [31:0] wd);
    cs_n = c; load_n = ld; adv_n = av; gw_n = g; bwe_n = bm; bw_n = b; addr = a; wdata = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_rd(input logic [AW-1:0] a);
    step(0, 0, 1, 1, 1, 4'hF, a, '0);
  endtask
  task automatic adv_rd(input logic [31:0] wd);
    step(0, 1, 0, 1, 1, 4'hF, '0, wd);
  endtask
  task automatic hold_rd(input logic [31:0] wd);
    step(0, 1, 1, 1, 1, 4'hF, '0, wd);
  endtask
  task automatic write_word(input logic [AW-1:0] a, input logic [31:0] d);
    step(0, 0, 1, 0, 1, 4'hF, a, '0);
    hold_rd(d);
  endtask
  task automatic desel();
    step(1, 1, 1, 1, 1, 4'hF, '0, '0);
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'hB000_0000 + a;
  endfunction

  task automatic burst(input int start, input logic ilv, input string req);
    int exp_a;
    ilv_mode = ilv;
    load_rd(start);
    check(req, rdata, pat(start));
    for (int k = 1; k < 5; k++) begin
      adv_rd('0);
      exp_a = ilv ? ((start & ~3) | ((start ^ k) & 3)) : ((start & ~3) | ((start + k) & 3));
      check(req, rdata, pat(exp_a));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    @(negedge clk); @(negedge clk);
    check("R12 drive off in reset", {31'b0, rdata_en}, 0);
    rst_n = 1;
    step(0, 1, 0, 1, 1, 4'hF, '0, '0);
    check("R12 no access after reset", {31'b0, rdata_en}, 0);

    // Write-enable decode table (R5, R6, R7, R8)
    foreach (VEC[i]) begin
      write_word(i, 32'h1122_3344);
      check("R8 read after write", rdata, 32'h1122_3344);
      step(0, 0, 1, VEC[i][9], VEC[i][8], VEC[i][7:4], i, '0);
      if (VEC[i][3:0] != 0) check("R9 no drive in write cycle", {31'b0, rdata_en}, 0);
      hold_rd(32'hAABB_CCDD);
      for (int n = 0; n < 4; n++)
        exp[8*n +: 8] = VEC[i][n] ? 8'hAA + 8'h00 : 8'h00;
      exp = 32'h1122_3344;
      for (int n = 0; n < 4; n++)
        if (VEC[i][n]) exp[8*n +: 8] = 8'(32'hAABB_CCDD >> (8*n));
      check(i < 2 ? "R5 global write" : (i < 5 ? "R6 lane write" : "R7 read ignores lanes"),
            rdata, exp);
      desel();
    end

    for (int a = 16; a < 24; a++) write_word(a, pat(a));
    desel();

    burst(17, 1, "R2 interleaved start 01");
    burst(18, 1, "R2 interleaved start 10");
    burst(17, 0, "R3 linear start 01");
    burst(23, 0, "R3 linear start 11");

    ilv_mode = 0;
    load_rd(20);
    adv_rd('0);
    hold_rd('0);
    check("R4 hold address", rdata, pat(21));
    hold_rd('0);
    check("R4 hold address", rdata, pat(21));
    check("R1 loaded access", {31'b0, rdata_en}, 1);

    oe_n = 1; #1;
    check("R9 oe high drops drive", {31'b0, rdata_en}, 0);
    oe_n = 0; #1;
    check("R9 oe low restores drive", rdata, pat(21));
    @(negedge clk);

    desel();
    check("R10 deselect no drive", {31'b0, rdata_en}, 0);
    adv_rd('0);
    check("R10 advance after deselect", {31'b0, rdata_en}, 0);
    load_rd(22);
    check("R1 reload after deselect", rdata, pat(22));

    sleep = 1; #1;
    check("R11 sleep drops drive", {31'b0, rdata_en}, 0);
    @(negedge clk);
    sleep = 0;
    hold_rd('0);
    check("R11 access ended by sleep", {31'b0, rdata_en}, 0);

    step(0, 0, 1, 0, 1, 4'hF, 20, '0);
    sleep = 1;
    step(0, 1, 1, 1, 1, 4'hF, '0, 32'hDEAD_BEEF);
    sleep = 0;
    load_rd(20);
    check("R11 write dropped in sleep", rdata, pat(20));
    load_rd(16);
    check("R11 contents kept", rdata, pat(16));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule